// File: doc/BRIEF.md
# Dual Programmable PWM Clock Divider

This block derives two independent clock-enable pulse trains, A and B, from the master clock for a bank of PWM channels. A free-running prescaler provides power-of-two enable taps, from divide-by-1 up to divide-by-1024. Each of the two slots picks one tap and then divides it by an 8-bit linear divisor. The rate of each output is therefore the master clock divided by 2^exponent times divisor. PWM channels outside this block choose the master clock, one of the prescaler taps, or output A or B as their counting clock.

Both slots are set through one 32-bit mode register. Slot A is held in the low 16 bits and slot B in the high 16 bits. A bus write carries one strobe per half, so software can set or release either slot without touching the other. A slot whose divisor is zero produces no pulses. Writing zero to a half therefore turns that clock off. Every write to a half restarts that slot's divider, so the new rate takes effect from the write without a short first period.

Top module: `pwm_clkdiv_pair`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mode_q` reads zero and both `clka_en` and `clkb_en` are low.
- R2: A write with `wr_lo` high loads `wr_data[15:0]` into `mode_q[15:0]`. A write with `wr_hi` high loads `wr_data[31:16]` into `mode_q[31:16]`. A half whose strobe is low keeps its value.
- R3: Within each half, bits [7:0] are the linear divisor and bits [11:8] are the exponent. Bits [15:12] are stored and read back but do not affect the output.
- R4: `tap_en[k]` for k = 0..10 is a one-cycle pulse that repeats every 2^k cycles. `tap_en[0]` is therefore high in every cycle.
- R5: With divisor d in 1..255 and exponent p in 0..10, the slot's output pulses repeat every 2^p × d master-clock cycles.
- R6: Each output pulse lasts one cycle. The one exception is p = 0 with d = 1, where the output is high in every cycle.
- R7: A slot whose divisor field is zero, which includes an all-zero half, keeps its output low.
- R8: A slot whose exponent field is 11 to 15 keeps its output low, whatever its divisor.
- R9: A write to a half forces that slot's output low in the next cycle and restarts its divider. With exponent 0, the first new pulse appears exactly d cycles after the write edge.
- R10: A write to one half does not shift or interrupt the pulse train of the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_lo | input | 1 | Write strobe for the low half (slot A) |
| wr_hi | input | 1 | Write strobe for the high half (slot B) |
| wr_data | input | 32 | Write data for the mode register |
| mode_q | output | 32 | Current mode register contents |
| tap_en | output | 11 | Prescaler enable taps, bit k pulses every 2^k cycles |
| clka_en | output | 1 | Slot A clock-enable pulse |
| clkb_en | output | 1 | Slot B clock-enable pulse |

## Verification
The divider is driven from a vector table that covers both slots. The table includes exponent 0 with divisors 2, 3 and 255, which shows that the linear counter reloads at the right count. It includes exponents 1, 2 and 3 with small divisors, which shows that the chosen tap is the one used. Exponent 10 with small divisors and exponent 4 with divisor 255 show that the full tap range is reached and that the product does not overflow. The interval between pulses separates a wrong tap (an error by a power of two) from a wrong reload (an error by one tap period). Directed cases use exponent codes above 10, zero divisors, spare-bit patterns and a rewrite while a long count is in progress. These cases show whether out-of-range settings are ignored and whether a restart leaves a runt pulse. Writes to slot A in every few cycles, made while slot B is checked against a fixed phase, show that the two slots are isolated.

// File: rtl/pwmdiv_pkg.sv
// Shared sizing for the dual PWM clock divider.
// Assumes two 16-bit slots packed into one 32-bit mode register.
package pwmdiv_pkg;
    localparam int MAX_EXP    = 10;               // largest usable exponent
    localparam int NUM_TAPS   = MAX_EXP + 1;      // taps 2^0 .. 2^MAX_EXP
    localparam int DIV_W      = 8;                // linear divisor width
    localparam int EXP_W      = 4;                // exponent field width
    localparam int HALF_W     = 16;               // one slot in the register
    localparam int NUM_HALVES = 2;                // slots A and B
    localparam int MODE_W     = HALF_W * NUM_HALVES;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [EXP_W-1:0]  exp_t;
endpackage

// File: rtl/pwmdiv_modereg.sv
// Mode register with one write strobe per half.
// Purpose: hold both slot settings and flag a restart for each written half.
// Assumes the strobes are synchronous to clk. A strobe that is high loads its half on the edge.
module pwmdiv_modereg
    import pwmdiv_pkg::*;
#(
    parameter int HW = HALF_W,
    parameter int NH = NUM_HALVES,
    localparam int MW = HW * NH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NH-1:0] wr_i,
    input  logic [MW-1:0] wr_data_i,
    output logic [MW-1:0] mode_o,
    output logic [NH-1:0] restart_o
);

    for (genvar h = 0; h < NH; h++) begin : g_half
        logic [HW-1:0] half_q;

        // Load this half when its strobe is high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (wr_i[h]) begin
                half_q <= wr_data_i[h*HW +: HW];
            end
        end

        assign mode_o[h*HW +: HW] = half_q;
    end

    // A write restarts the divider of the half it touches, on the same edge.
    assign restart_o = wr_i;

endmodule

// File: rtl/pwmdiv_prescaler.sv
// Free-running power-of-two prescaler.
// Purpose: tap k gives a one-cycle enable every 2^k master-clock cycles.
// Assumes NT >= 2. Tap 0 is the undivided master clock (always enabled).
module pwmdiv_prescaler #(
    parameter int NT = pwmdiv_pkg::NUM_TAPS,
    localparam int CW = NT - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [NT-1:0] tap_o
);

    logic [CW-1:0] cnt_q;

    // Count master-clock cycles. The counter wraps freely.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Tap k fires when the low k counter bits are all ones.
    for (genvar k = 0; k < NT; k++) begin : g_tap
        if (k == 0) begin : g_base
            assign tap_o[k] = 1'b1;
        end else begin : g_div
            assign tap_o[k] = &cnt_q[k-1:0];
        end
    end

endmodule

// File: rtl/pwmdiv_lindiv.sv
// Linear divider for one slot.
// Purpose: count pulses of the selected prescaler tap and emit one enable every divisor taps.
// Assumes restart_i is high in the cycle the slot's settings change.
// A zero divisor or an exponent above the last tap disables the slot.
module pwmdiv_lindiv #(
    parameter int NT = pwmdiv_pkg::NUM_TAPS,
    parameter int DW = pwmdiv_pkg::DIV_W,
    parameter int EW = pwmdiv_pkg::EXP_W,
    localparam int PAD_W = 1 << EW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [DW-1:0] div_i,
    input  logic [EW-1:0] exp_i,
    input  logic [NT-1:0] tap_i,
    output logic          pulse_o
);

    logic [DW-1:0]    cnt_q;
    logic [PAD_W-1:0] tap_pad;
    logic             slot_on;
    logic             tap_hit;
    logic             at_last;

    // Pad the taps so that exponent codes past the last tap select a constant zero.
    assign tap_pad = PAD_W'(tap_i);

    // The slot runs only with a non-zero divisor and an exponent in range.
    assign slot_on = (div_i != '0) && (32'(exp_i) < NT);
    assign tap_hit = slot_on && tap_pad[exp_i];
    assign at_last = (cnt_q == div_i - DW'(1));

    // Advance the count on each selected tap. Reload and pulse at the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !slot_on) begin
            cnt_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= tap_hit && at_last;
            if (tap_hit) begin
                cnt_q <= at_last ? '0 : cnt_q + DW'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_clkdiv_pair.sv
// Dual programmable PWM clock divider, top level.
// Purpose: two slots (A in the low half, B in the high half) each divide the
// master clock by 2^exp * div, sharing one prescaler and one mode register.
// Assumes a single clock domain and a synchronous active-low reset.
module pwm_clkdiv_pair
    import pwmdiv_pkg::*;
#(
    parameter int P_MAX_EXP = MAX_EXP,
    localparam int NT = P_MAX_EXP + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [MODE_W-1:0] wr_data,
    output logic [MODE_W-1:0] mode_q,
    output logic [NT-1:0]     tap_en,
    output logic              clka_en,
    output logic              clkb_en
);

    logic [NUM_HALVES-1:0] restart;
    logic [NUM_HALVES-1:0] slot_en;

    pwmdiv_modereg #(.HW(HALF_W), .NH(NUM_HALVES)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      ({wr_hi, wr_lo}),
        .wr_data_i (wr_data),
        .mode_o    (mode_q),
        .restart_o (restart)
    );

    pwmdiv_prescaler #(.NT(NT)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tap_o (tap_en)
    );

    // One linear divider per slot, fed from its half of the mode register.
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_slot
        pwmdiv_lindiv #(.NT(NT), .DW(DIV_W), .EW(EXP_W)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart[h]),
            .div_i     (mode_q[h*HALF_W +: DIV_W]),
            .exp_i     (mode_q[h*HALF_W + DIV_W +: EXP_W]),
            .tap_i     (tap_en),
            .pulse_o   (slot_en[h])
        );
    end

    assign clka_en = slot_en[0];
    assign clkb_en = slot_en[1];

endmodule

// File: rtl/pwm_clkdiv_pair_chk.sv
// Property checker for pwm_clkdiv_pair, attached with bind below.
// Assumes the default field layout: divisor [7:0], exponent [11:8] in each half.
module pwm_clkdiv_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_lo,
    input logic        wr_hi,
    input logic [31:0] wr_data,
    input logic [31:0] mode_q,
    input logic [10:0] tap_en,
    input logic        clka_en,
    input logic        clkb_en
);

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> mode_q[15:0] == $past(wr_data[15:0]));                    // R2
    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(mode_q[31:16]));                                 // R2
    AST_TAP1_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        tap_en[1] |=> !tap_en[1]);                                          // R4
    AST_A_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clka_en && !wr_lo && mode_q[11:0] != 12'h001 |=> !clka_en);         // R6
    AST_A_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[7:0] == 8'd0 |-> !clka_en);                                  // R7
    AST_B_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[23:16] == 8'd0 |-> !clkb_en);                                // R7
    AST_A_BIG_EXP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[11:8] > 4'd10 |-> !clka_en);                                 // R8
    AST_B_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> !clkb_en);                                                // R9

endmodule

bind pwm_clkdiv_pair pwm_clkdiv_pair_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .mode_q  (mode_q),
    .tap_en  (tap_en),
    .clka_en (clka_en),
    .clkb_en (clkb_en)
);

// File: tb/sim_pwm_clkdiv_pair.sv
`timescale 1ns/1ps
module sim_pwm_clkdiv_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_lo = 1'b0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] mode_q;
    logic [10:0] tap_en;
    logic        clka_en;
    logic        clkb_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_clkdiv_pair u0 (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .mode_q(mode_q), .tap_en(tap_en), .clka_en(clka_en), .clkb_en(clkb_en)
    );

    // Vector entry: {hi_slot, exponent[3:0], divisor[7:0], expected period[11:0]}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 4'd0,  8'd2,   12'd2},
        {1'b0, 4'd0,  8'd255, 12'd255},
        {1'b0, 4'd1,  8'd1,   12'd2},
        {1'b0, 4'd3,  8'd5,   12'd40},
        {1'b0, 4'd10, 8'd1,   12'd1024},
        {1'b0, 4'd6,  8'd13,  12'd832},
        {1'b1, 4'd0,  8'd3,   12'd3},
        {1'b1, 4'd2,  8'd7,   12'd28},
        {1'b1, 4'd10, 8'd2,   12'd2048},
        {1'b1, 4'd4,  8'd255, 12'd4080}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic lo, input logic hi, input logic [31:0] d);
        @(negedge clk);
        wr_lo = lo; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
    endtask

    function automatic logic sel_out(input bit hi);
        return hi ? clkb_en : clka_en;
    endfunction

    // Wait for the next high sample of the chosen output. Returns its cycle, or -1 on timeout.
    task automatic wait_high(input bit hi, input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (sel_out(hi)) begin at = cyc; break; end
        end
    endtask

    // Measure the width of one pulse and the interval to the next pulse.
    task automatic measure(input bit hi, output int gap, output int width);
        int t1, t2;
        wait_high(hi, 10000, t1);
        width = 0;
        gap = -1;
        if (t1 < 0) return;
        width = 1;
        forever begin
            @(negedge clk);
            if (!sel_out(hi)) break;
            width++;
            if (width > 5000) return;
        end
        wait_high(hi, 10000, t2);
        if (t2 >= 0) gap = t2 - t1;
    endtask

    // Measure the repeat interval of one prescaler tap.
    task automatic tap_gap(input int k, output int gap);
        int t1;
        t1 = -1; gap = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (tap_en[k]) begin
                if (t1 < 0) t1 = cyc;
                else begin gap = cyc - t1; break; end
            end
        end
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int gap, width, t;
        logic [31:0] d;
        bit seen;

        // R1: reset state, while held and right after release
        repeat (4) @(negedge clk);
        check(mode_q == 0 && !clka_en && !clkb_en, "R1 in reset", int'(mode_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mode_q == 0 && !clka_en && !clkb_en, "R1 after release", int'(mode_q), 0);

        // R4: prescaler taps
        seen = 1'b1;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (!tap_en[0]) seen = 1'b0; end
        check(seen, "R4 tap0 always high", int'(seen), 1);
        tap_gap(3, gap);   check(gap == 8, "R4 tap3 interval", gap, 8);
        tap_gap(10, gap);  check(gap == 1024, "R4 tap10 interval", gap, 1024);

        // R2: per-half write strobes
        write_mode(1'b1, 1'b0, 32'hABCD_1234);
        check(mode_q == 32'h0000_1234, "R2 low half load", int'(mode_q), 32'h0000_1234);
        write_mode(1'b0, 1'b1, 32'h5678_FFFF);
        check(mode_q == 32'h5678_1234, "R2 high half load", int'(mode_q), 32'h5678_1234);

        // R5, R6: vector table over both slots
        for (int v = 0; v < NV; v++) begin
            bit hi;
            int p, dv, per;
            hi = VEC[v][24];
            p = int'(VEC[v][23:20]);
            dv = int'(VEC[v][19:12]);
            per = int'(VEC[v][11:0]);
            d = {16'h0, 4'h0, VEC[v][23:20], VEC[v][19:12]};
            if (hi) d = {d[15:0], 16'h0};
            write_mode(1'b1, 1'b1, d);
            measure(hi, gap, width);
            check(gap == per, $sformatf("R5 period p=%0d d=%0d slot=%0d", p, dv, hi), gap, per);
            check(width == 1, "R6 pulse width", width, 1);
        end

        // R6: exponent 0 with divisor 1 is continuously high
        write_mode(1'b1, 1'b0, 32'h0000_0001);
        seen = 1'b1;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (!clka_en) seen = 1'b0; end
        check(seen, "R6 continuous at p0 d1", int'(seen), 1);

        // R3: spare bits [15:12] have no effect, and read back
        write_mode(1'b1, 1'b0, 32'h0000_F105);
        check(mode_q[15:0] == 16'hF105, "R3 spare bits stored", int'(mode_q[15:0]), 16'hF105);
        measure(1'b0, gap, width);
        check(gap == 10, "R3 spare bits ignored", gap, 10);

        // R7: zero divisor, and an all-zero half, stay low
        write_mode(1'b1, 1'b1, 32'h0000_0300);
        wait_high(1'b0, 3000, t);
        check(t < 0, "R7 zero divisor slot A", t, -1);
        wait_high(1'b1, 200, t);
        check(t < 0, "R7 zero half slot B", t, -1);

        // R8: exponent codes above 10 disable the slot
        write_mode(1'b1, 1'b0, 32'h0000_0B05);
        wait_high(1'b0, 3000, t);
        check(t < 0, "R8 exponent 11", t, -1);
        write_mode(1'b1, 1'b0, 32'h0000_0F01);
        wait_high(1'b0, 3000, t);
        check(t < 0, "R8 exponent 15", t, -1);

        // R9: a rewrite mid-count restarts cleanly
        write_mode(1'b1, 1'b0, 32'h0000_00C8);
        repeat (150) @(negedge clk);
        write_mode(1'b1, 1'b0, 32'h0000_0064);
        check(!clka_en, "R9 low after write", int'(clka_en), 0);
        t = cyc;
        wait_high(1'b0, 400, gap);
        check(gap - t == 100, "R9 first pulse after restart", gap - t, 100);

        // R10: writes to slot A leave slot B's phase intact
        write_mode(1'b1, 1'b1, 32'h0007_0000);
        wait_high(1'b1, 100, t);
        seen = 1'b1;
        for (int i = 1; i <= 70; i++) begin
            wr_lo = (i % 5 == 0);
            wr_data = {16'h0, 8'h0, 8'(i)};
            @(negedge clk);
            if (clkb_en != ((cyc - t) % 7 == 0)) seen = 1'b0;
        end
        wr_lo = 1'b0;
        check(seen, "R10 slot B undisturbed", int'(seen), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule